// File: doc/BRIEF.md
# Low-Power Stop Sequencer

This block decides how deeply a small microcontroller sleeps when its processor executes a stop instruction, and it drives the power and clock controls that go with that depth. A one-cycle strobe starts the entry. Two power-down select inputs name the requested depth, which is one of three stop levels. Level 1 is the deepest and level 3 the shallowest.

The requested depth is not always granted. When on-chip debug is enabled, or when supply-voltage monitoring is armed for stop, the block enters level 3 instead. It then keeps the regulator and/or the clock generator awake, depending on which feature forced the demotion.

While the device is stopped, the block does the following:
- It gates the peripheral clocks.
- It freezes the I/O pins.
- It answers debug memory accesses with an error status instead of touching memory.

Three events wake the device:
- an interrupt;
- a low-voltage event, when voltage monitoring is armed for stop;
- a debug background request, when debug was enabled at entry.

On wake, the block spends one transition cycle with the hold released and the clocks back on. It then returns to run, or to a halted debug state. It records which stop level was exited.

Top module: `lpstop_ctrl`

## Requirements
- R1: When `stop_req` is high in run, `mode` on the next cycle shows the selected level. The encoding is: `pd_sel`=1 and `pd_partial`=0 gives 1; `pd_sel`=1 and `pd_partial`=1 gives 2; `pd_sel`=0 gives 3, whatever `pd_partial` is.
- R2: If `dbg_enable` is high at entry, any request becomes level 3. During that stop `dbg_clk_en`=1, `osc_standby`=0 and `reg_standby`=0.
- R3: If `lv_enable` and `lv_stop_enable` are both high at entry, any request becomes level 3. Without debug, that stop gives `reg_standby`=0 and `osc_standby`=1. Either bit alone demotes nothing.
- R4: A stop entered with neither debug nor armed monitoring gives `reg_standby`=1, `osc_standby`=1 and `dbg_clk_en`=0.
- R5: In every stop level, `periph_clk_en`=0 and `io_hold`=1, even with debug enabled. In run, `periph_clk_en`=1 and `io_hold`=0.
- R6: `rti_clk_en` is 1 outside stop. In level 3 it follows `rti_keep`. In levels 1 and 2 it is 0.
- R7: When `wake_irq` is seen in stop, the next cycle shows the following:
  - `mode`=4 (wake);
  - `io_hold`=0 and `periph_clk_en`=1;
  - `last_exit` holds the level that was left.
  
  The cycle after that shows `mode`=0 (run).
- R8: `dbg_bkgnd` in stop wakes the device only if debug was enabled at entry. It then passes through wake into `mode`=5 with `bg_active`=1. `stop_req` is ignored in mode 5, and `dbg_resume` returns to run. `dbg_bkgnd` in run with `dbg_enable` also enters mode 5.
- R9: A `dbg_mem_req` in stop, or while `wait_active` is high, holds `dbg_mem_grant` at 0 and is answered one cycle later with `dbg_mem_done`=1 and `dbg_mem_err`=1. Outside those states the request is granted in the same cycle and answered with `dbg_mem_err`=0.
- R10: `lv_trip` is a qualifying event in run when `lv_enable` is high, and in stop only when monitoring was armed at entry. A qualifying event raises, one cycle later, `lv_reset` if `lv_reset_sel`=1, else `lv_irq`. In stop it also wakes the device.
- R11: After reset the block is in run: `mode`=0, `last_exit`=0, clocks enabled, no hold and no standby requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop instruction strobe |
| pd_sel | input | 1 | Power-down select |
| pd_partial | input | 1 | Partial power-down select |
| dbg_enable | input | 1 | Debug enabled |
| lv_enable | input | 1 | Low-voltage detector enabled |
| lv_stop_enable | input | 1 | Low-voltage detector kept on in stop |
| lv_reset_sel | input | 1 | Low-voltage event gives reset (1) or interrupt (0) |
| lv_trip | input | 1 | Supply below threshold |
| wake_irq | input | 1 | Interrupt wake request |
| dbg_bkgnd | input | 1 | Debug background request |
| dbg_resume | input | 1 | Leave halted debug state |
| dbg_mem_req | input | 1 | Debug memory access with status |
| wait_active | input | 1 | Processor is in wait |
| rti_keep | input | 1 | Keep periodic wake timer running in level 3 |
| periph_clk_en | output | 1 | Peripheral clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_standby | output | 1 | Regulator standby request |
| osc_standby | output | 1 | Clock generator standby request |
| io_hold | output | 1 | Freeze I/O pin states |
| rti_clk_en | output | 1 | Periodic wake timer clock enable |
| mode | output | 3 | Current mode: 0 run, 1-3 stop level, 4 wake, 5 halted debug |
| last_exit | output | 3 | Stop level most recently exited |
| bg_active | output | 1 | Halted debug state, all debug commands accepted |
| dbg_mem_grant | output | 1 | Debug memory access may proceed |
| dbg_mem_done | output | 1 | Debug memory status ready |
| dbg_mem_err | output | 1 | Status: access refused, device stopped or waiting |
| lv_irq | output | 1 | Low-voltage interrupt |
| lv_reset | output | 1 | Low-voltage reset request |

## Verification
The bench applies every combination of select and feature bits that changes the granted level.

It gives particular attention to the following cases:
- **Partial bit with `pd_sel` low.** A design that decodes the partial bit in that case would enter level 2.
- **Debug and monitoring both enabled.** A design that let monitoring win would put the clock generator in standby and lose the debug link.
- **Only one monitoring bit set.** A design that demoted here would waste power.

The bench also checks the following:
- A background request is ignored in a stop entered without debug. A design that woke here would break the stop.
- A stop strobe is ignored in the halted debug state.
- A low-voltage trip wakes the device only when monitoring was armed at entry. A design that woke otherwise would leave the deepest levels on noise.
- Debug memory accesses are refused in both stop and wait. A design that granted them would read memory through a gated clock.

// File: rtl/lpstop_pkg.sv
`timescale 1ns/1ps
package lpstop_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_RUN   = 3'd0,
        M_STOP1 = 3'd1,
        M_STOP2 = 3'd2,
        M_STOP3 = 3'd3,
        M_WAKE  = 3'd4,
        M_ACTBG = 3'd5
    } pmode_e;

    typedef struct packed {
        logic pdc;
        logic ppdc;
        logic dbg_en;
        logic lv_en;
        logic lv_stop_en;
    } stop_cfg_t;

    typedef struct packed {
        pmode_e target;
        logic   keep_dbg;
        logic   keep_lvd;
    } stop_plan_t;

    typedef struct packed {
        logic periph_clk;
        logic dbg_clk;
        logic reg_sb;
        logic osc_sb;
        logic io_hold;
        logic rti_clk;
    } pwr_ctl_t;

    function automatic logic is_stop(pmode_e m);
        return (m == M_STOP1) || (m == M_STOP2) || (m == M_STOP3);
    endfunction

    function automatic pmode_e requested_level(logic pdc, logic ppdc);
        if (!pdc)
            return M_STOP3;
        return ppdc ? M_STOP2 : M_STOP1;
    endfunction

endpackage

// File: rtl/lpstop_select.sv
`timescale 1ns/1ps
module lpstop_select
    import lpstop_pkg::*;
(
    input  stop_cfg_t  cfg_i,
    output stop_plan_t plan_o
);
    logic lvd_armed;

    always_comb begin
        lvd_armed        = cfg_i.lv_en & cfg_i.lv_stop_en;
        plan_o.keep_dbg  = cfg_i.dbg_en;
        plan_o.keep_lvd  = lvd_armed;
        if (cfg_i.dbg_en || lvd_armed)
            plan_o.target = M_STOP3;
        else
            plan_o.target = requested_level(cfg_i.pdc, cfg_i.ppdc);
    end
endmodule

// File: rtl/lpstop_seq.sv
`timescale 1ns/1ps
module lpstop_seq
    import lpstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_i,
    input  stop_plan_t plan_i,
    input  logic       irq_i,
    input  logic       bkgnd_i,
    input  logic       dbg_en_i,
    input  logic       resume_i,
    input  logic       lv_wake_i,
    output pmode_e     state_o,
    output pmode_e     last_exit_o,
    output logic       keep_dbg_o,
    output logic       keep_lvd_o
);
    pmode_e state_q, last_q;
    logic   keep_dbg_q, keep_lvd_q, bg_pend_q;
    logic   wake_evt, bg_wake;

    always_comb begin
        bg_wake  = bkgnd_i & keep_dbg_q;
        wake_evt = irq_i | lv_wake_i | bg_wake;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= M_RUN;
            last_q     <= M_RUN;
            keep_dbg_q <= 1'b0;
            keep_lvd_q <= 1'b0;
            bg_pend_q  <= 1'b0;
        end else begin
            unique case (state_q)
                M_RUN: begin
                    if (stop_i) begin
                        state_q    <= plan_i.target;
                        keep_dbg_q <= plan_i.keep_dbg;
                        keep_lvd_q <= plan_i.keep_lvd;
                    end else if (bkgnd_i && dbg_en_i) begin
                        state_q <= M_ACTBG;
                    end
                end
                M_STOP1, M_STOP2, M_STOP3: begin
                    if (wake_evt) begin
                        state_q   <= M_WAKE;
                        last_q    <= state_q;
                        bg_pend_q <= bg_wake;
                    end
                end
                M_WAKE: begin
                    state_q    <= bg_pend_q ? M_ACTBG : M_RUN;
                    bg_pend_q  <= 1'b0;
                    keep_dbg_q <= 1'b0;
                    keep_lvd_q <= 1'b0;
                end
                M_ACTBG: begin
                    if (resume_i)
                        state_q <= M_RUN;
                end
                default: state_q <= M_RUN;
            endcase
        end
    end

    assign state_o     = state_q;
    assign last_exit_o = last_q;
    assign keep_dbg_o  = keep_dbg_q;
    assign keep_lvd_o  = keep_lvd_q;

    // R1: a strobe in run always lands in a stop level
    a_r1_enter_stop: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_RUN && stop_i) |=> is_stop(state_q));

    // R2: debug enabled at entry forces the shallowest level
    a_r2_dbg_demote: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_RUN && stop_i && dbg_en_i) |=> (state_q == M_STOP3));

    // R7: the wake cycle lasts exactly one cycle
    a_r7_wake_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_WAKE) |=> (state_q == M_RUN || state_q == M_ACTBG));
endmodule

// File: rtl/lpstop_pwrdec.sv
`timescale 1ns/1ps
module lpstop_pwrdec
    import lpstop_pkg::*;
(
    input  pmode_e   state_i,
    input  logic     keep_dbg_i,
    input  logic     keep_lvd_i,
    input  logic     dbg_en_i,
    input  logic     rti_keep_i,
    output pwr_ctl_t ctl_o
);
    logic stopped;

    always_comb begin
        stopped          = is_stop(state_i);
        ctl_o.periph_clk = !stopped;
        ctl_o.io_hold    = stopped;
        ctl_o.dbg_clk    = stopped ? keep_dbg_i : dbg_en_i;
        ctl_o.reg_sb     = stopped & !keep_dbg_i & !keep_lvd_i;
        ctl_o.osc_sb     = stopped & !keep_dbg_i;
        ctl_o.rti_clk    = !stopped | ((state_i == M_STOP3) & rti_keep_i);
    end
endmodule

// File: rtl/lpstop_lvmon.sv
`timescale 1ns/1ps
module lpstop_lvmon (
    input  logic clk,
    input  logic rst,
    input  logic trip_i,
    input  logic lv_en_i,
    input  logic rst_sel_i,
    input  logic stopped_i,
    input  logic keep_lvd_i,
    output logic evt_o,
    output logic irq_o,
    output logic reset_o
);
    always_comb
        evt_o = trip_i & (stopped_i ? keep_lvd_i : lv_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o   <= 1'b0;
            reset_o <= 1'b0;
        end else begin
            irq_o   <= evt_o & !rst_sel_i;
            reset_o <= evt_o & rst_sel_i;
        end
    end
endmodule

// File: rtl/lpstop_dbgport.sv
`timescale 1ns/1ps
module lpstop_dbgport (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic stopped_i,
    input  logic wait_i,
    output logic grant_o,
    output logic done_o,
    output logic err_o
);
    logic blocked;

    always_comb begin
        blocked = stopped_i | wait_i;
        grant_o = req_i & !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= req_i;
            err_o  <= req_i & blocked;
        end
    end
endmodule

// File: rtl/lpstop_ctrl.sv
`timescale 1ns/1ps
module lpstop_ctrl
    import lpstop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic              pd_sel,
    input  logic              pd_partial,
    input  logic              dbg_enable,
    input  logic              lv_enable,
    input  logic              lv_stop_enable,
    input  logic              lv_reset_sel,
    input  logic              lv_trip,
    input  logic              wake_irq,
    input  logic              dbg_bkgnd,
    input  logic              dbg_resume,
    input  logic              dbg_mem_req,
    input  logic              wait_active,
    input  logic              rti_keep,
    output logic              periph_clk_en,
    output logic              dbg_clk_en,
    output logic              reg_standby,
    output logic              osc_standby,
    output logic              io_hold,
    output logic              rti_clk_en,
    output logic [MODE_W-1:0] mode,
    output logic [MODE_W-1:0] last_exit,
    output logic              bg_active,
    output logic              dbg_mem_grant,
    output logic              dbg_mem_done,
    output logic              dbg_mem_err,
    output logic              lv_irq,
    output logic              lv_reset
);
    stop_cfg_t  cfg;
    stop_plan_t plan;
    pmode_e     state, last_mode;
    logic       keep_dbg, keep_lvd, stopped, lv_evt;
    pwr_ctl_t   ctl;

    assign cfg = '{pdc: pd_sel, ppdc: pd_partial, dbg_en: dbg_enable,
                   lv_en: lv_enable, lv_stop_en: lv_stop_enable};

    lpstop_select u_select (.cfg_i(cfg), .plan_o(plan));

    lpstop_seq u_seq (
        .clk(clk), .rst(rst), .stop_i(stop_req), .plan_i(plan),
        .irq_i(wake_irq), .bkgnd_i(dbg_bkgnd), .dbg_en_i(dbg_enable),
        .resume_i(dbg_resume), .lv_wake_i(lv_evt),
        .state_o(state), .last_exit_o(last_mode),
        .keep_dbg_o(keep_dbg), .keep_lvd_o(keep_lvd)
    );

    assign stopped = is_stop(state);

    lpstop_pwrdec u_pwrdec (
        .state_i(state), .keep_dbg_i(keep_dbg), .keep_lvd_i(keep_lvd),
        .dbg_en_i(dbg_enable), .rti_keep_i(rti_keep), .ctl_o(ctl)
    );

    lpstop_lvmon u_lvmon (
        .clk(clk), .rst(rst), .trip_i(lv_trip), .lv_en_i(lv_enable),
        .rst_sel_i(lv_reset_sel), .stopped_i(stopped), .keep_lvd_i(keep_lvd),
        .evt_o(lv_evt), .irq_o(lv_irq), .reset_o(lv_reset)
    );

    lpstop_dbgport u_dbgport (
        .clk(clk), .rst(rst), .req_i(dbg_mem_req), .stopped_i(stopped),
        .wait_i(wait_active), .grant_o(dbg_mem_grant),
        .done_o(dbg_mem_done), .err_o(dbg_mem_err)
    );

    assign periph_clk_en = ctl.periph_clk;
    assign dbg_clk_en    = ctl.dbg_clk;
    assign reg_standby   = ctl.reg_sb;
    assign osc_standby   = ctl.osc_sb;
    assign io_hold       = ctl.io_hold;
    assign rti_clk_en    = ctl.rti_clk;
    assign mode          = state;
    assign last_exit     = last_mode;
    assign bg_active     = (state == M_ACTBG);

    // R5: no stop level leaves peripheral clocks on or pins free
    a_r5_stop_gating: assert property (@(posedge clk) disable iff (rst)
        is_stop(pmode_e'(mode)) |-> (!periph_clk_en && io_hold));

    // R9: a refused memory access is never granted
    a_r9_no_access: assert property (@(posedge clk) disable iff (rst)
        (dbg_mem_req && (stopped || wait_active)) |-> !dbg_mem_grant);

    // R10: a low-voltage trip during stop without armed monitoring leaves the state alone
    a_r10_unarmed_hold: assert property (@(posedge clk) disable iff (rst)
        (stopped && !keep_lvd && !wake_irq && !(dbg_bkgnd && keep_dbg)) |=> $stable(mode));
endmodule

// File: tb/test_lpstop_ctrl.sv
`timescale 1ns/1ps
module test_lpstop_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 0, pd_sel = 0, pd_partial = 0, dbg_enable = 0;
    logic lv_enable = 0, lv_stop_enable = 0, lv_reset_sel = 0, lv_trip = 0;
    logic wake_irq = 0, dbg_bkgnd = 0, dbg_resume = 0, dbg_mem_req = 0;
    logic wait_active = 0, rti_keep = 0;
    logic periph_clk_en, dbg_clk_en, reg_standby, osc_standby, io_hold, rti_clk_en;
    logic [2:0] mode, last_exit;
    logic bg_active, dbg_mem_grant, dbg_mem_done, dbg_mem_err, lv_irq, lv_reset;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lpstop_ctrl i_lpstop_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req), .pd_sel(pd_sel),
        .pd_partial(pd_partial), .dbg_enable(dbg_enable), .lv_enable(lv_enable),
        .lv_stop_enable(lv_stop_enable), .lv_reset_sel(lv_reset_sel),
        .lv_trip(lv_trip), .wake_irq(wake_irq), .dbg_bkgnd(dbg_bkgnd),
        .dbg_resume(dbg_resume), .dbg_mem_req(dbg_mem_req),
        .wait_active(wait_active), .rti_keep(rti_keep),
        .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en),
        .reg_standby(reg_standby), .osc_standby(osc_standby), .io_hold(io_hold),
        .rti_clk_en(rti_clk_en), .mode(mode), .last_exit(last_exit),
        .bg_active(bg_active), .dbg_mem_grant(dbg_mem_grant),
        .dbg_mem_done(dbg_mem_done), .dbg_mem_err(dbg_mem_err),
        .lv_irq(lv_irq), .lv_reset(lv_reset)
    );

    // {pdc, ppdc, dbg, lv_en, lv_stop_en, rti_keep, mode[2:0], reg_sb, osc_sb, dbg_clk, rti}
    localparam int NVEC = 9;
    localparam logic [12:0] VEC [NVEC] = '{
        13'b100000_001_1100,  // R1 level 1
        13'b110001_010_1100,  // R1 level 2, R6 timer off
        13'b000001_011_1101,  // R1 level 3, R6 timer kept
        13'b010000_011_1100,  // R1 partial bit ignored
        13'b101000_011_0010,  // R2 debug demotes
        13'b110111_011_0101,  // R3 monitoring demotes
        13'b110100_010_1100,  // R3 lv_en alone
        13'b100010_001_1100,  // R3 stop enable alone, R4
        13'b111110_011_0010   // R2 R3 both
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R11 reset state
        chk("R11 mode", mode, 0);
        chk("R11 last_exit", last_exit, 0);
        chk("R11 periph", periph_clk_en, 1);
        chk("R11 hold", io_hold, 0);
        chk("R11 reg_sb", reg_standby, 0);
        chk("R11 osc_sb", osc_standby, 0);
        chk("R11 rti", rti_clk_en, 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            {pd_sel, pd_partial, dbg_enable, lv_enable, lv_stop_enable, rti_keep} = v[12:7];
            stop_req = 1;
            tick();
            stop_req = 0;
            chk("R1 R2 R3 mode", mode, int'(v[6:4]));
            chk("R2 R3 R4 reg_sb", reg_standby, v[3]);
            chk("R2 R3 R4 osc_sb", osc_standby, v[2]);
            chk("R2 R4 dbg_clk", dbg_clk_en, v[1]);
            chk("R6 rti", rti_clk_en, v[0]);
            chk("R5 periph", periph_clk_en, 0);
            chk("R5 hold", io_hold, 1);
            wake_irq = 1;
            tick();
            wake_irq = 0;
            chk("R7 wake mode", mode, 4);
            chk("R7 hold released", io_hold, 0);
            chk("R7 clocks back", periph_clk_en, 1);
            chk("R7 last_exit", last_exit, int'(v[6:4]));
            tick();
            chk("R7 run", mode, 0);
            {pd_sel, pd_partial, dbg_enable, lv_enable, lv_stop_enable, rti_keep} = '0;
        end

        // R8 background wake with debug
        dbg_enable = 1; pd_sel = 1; stop_req = 1;
        tick(); stop_req = 0;
        chk("R8 entry", mode, 3);
        dbg_bkgnd = 1; tick(); dbg_bkgnd = 0;
        chk("R8 wake", mode, 4);
        tick();
        chk("R8 actbg", mode, 5);
        chk("R8 bg_active", bg_active, 1);
        stop_req = 1; tick(); stop_req = 0;
        chk("R8 stop ignored", mode, 5);
        dbg_resume = 1; tick(); dbg_resume = 0;
        chk("R8 resume", mode, 0);
        dbg_enable = 0; pd_sel = 0;

        // R8 background ignored without debug, R9 in stop
        stop_req = 1; tick(); stop_req = 0;
        chk("R8 plain stop3", mode, 3);
        dbg_bkgnd = 1; tick(); dbg_bkgnd = 0;
        chk("R8 bkgnd ignored", mode, 3);
        dbg_mem_req = 1; #1;
        chk("R9 no grant stop", dbg_mem_grant, 0);
        tick(); dbg_mem_req = 0;
        chk("R9 done stop", dbg_mem_done, 1);
        chk("R9 err stop", dbg_mem_err, 1);
        wake_irq = 1; tick(); wake_irq = 0; tick();
        chk("R7 back to run", mode, 0);

        // R9 in run and in wait
        dbg_mem_req = 1; #1;
        chk("R9 grant run", dbg_mem_grant, 1);
        tick(); dbg_mem_req = 0;
        chk("R9 done run", dbg_mem_done, 1);
        chk("R9 no err run", dbg_mem_err, 0);
        wait_active = 1; dbg_mem_req = 1; #1;
        chk("R9 no grant wait", dbg_mem_grant, 0);
        tick(); dbg_mem_req = 0; wait_active = 0;
        chk("R9 err wait", dbg_mem_err, 1);

        // R10 events in run
        lv_enable = 1; lv_reset_sel = 0; lv_trip = 1;
        tick(); lv_trip = 0;
        chk("R10 irq", lv_irq, 1);
        chk("R10 no reset", lv_reset, 0);
        lv_reset_sel = 1; lv_trip = 1;
        tick(); lv_trip = 0;
        chk("R10 reset", lv_reset, 1);
        chk("R10 no irq", lv_irq, 0);
        lv_reset_sel = 0; tick();

        // R10 armed wake from stop3
        lv_stop_enable = 1; pd_sel = 1; stop_req = 1;
        tick(); stop_req = 0;
        chk("R10 armed entry", mode, 3);
        lv_trip = 1; tick(); lv_trip = 0;
        chk("R10 lv wake", mode, 4);
        chk("R10 lv irq in stop", lv_irq, 1);
        tick();
        chk("R10 run", mode, 0);

        // R10 unarmed trip in stop1 is ignored
        lv_stop_enable = 0; stop_req = 1;
        tick(); stop_req = 0;
        chk("R10 unarmed entry", mode, 1);
        lv_trip = 1; tick(); lv_trip = 0;
        chk("R10 no wake", mode, 1);
        chk("R10 no irq unarmed", lv_irq, 0);
        wake_irq = 1; tick(); wake_irq = 0; tick();
        chk("R7 final run", mode, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule